// File: doc/BRIEF.md
# Receive Frame Buffer with Error Filtering

This block sits between the byte stream coming out of an Ethernet receive MAC and the reader that moves frames into memory. Each incoming byte carries start and end markers; the end beat also carries three error flags: a frame check (FCS) failure, any other MAC-level error, and a failure reported by the checksum offload engine on the encapsulated payload only. Bytes are stored in a circular buffer together with a sideband end-of-frame bit and, on the final word, a status field. The reader takes them with a valid/ready handshake and sees a last flag on each frame's final byte.

Two buffering modes exist. In whole-frame mode a frame becomes readable only once its final byte is stored, which lets the block remove error frames by moving the write pointer back to where the frame began. In threshold mode a frame becomes readable as soon as enough of its bytes are stored, and nothing is removed. The mode, the error-forwarding controls and the threshold are captured when a frame starts, so a frame never changes its handling part-way through. A frame that would overrun the storage is cut short and tagged.

Top module: `rxFrameFifo`

## Requirements
- R1: After reset the read side shows no data (`rdValid` low) until a frame is written.
- R2: In whole-frame mode (`cfgStoreFwd`=1) no byte of a frame is readable before its end beat is stored; the frame becomes readable in the cycle after the write edge of its end beat.
- R3: In threshold mode (`cfgStoreFwd`=0) a frame becomes readable in the cycle after the write edge of the beat that brings its stored byte count to `cfgThreshold` (or to its end, if shorter).
- R4: Frames are read out whole and in arrival order; `rdLast` is high on a frame's final byte only, and data and last stay unchanged while `rdValid` is high and `rdReady` low.
- R5: In whole-frame mode with `cfgFwdErr`=0, a frame whose end status has the FCS bit or the MAC-error bit set is removed entirely; neighbouring frames are unaffected.
- R6: In whole-frame mode with `cfgFwdErr`=0, a frame whose only error is the payload checksum flag is kept when `cfgKeepCsum`=1 and removed when `cfgKeepCsum`=0; a checksum error together with an FCS error is always removed.
- R7: `rdStatus` is zero on every byte but the last; on the last byte it holds bit 0 FCS error, bit 1 MAC error, bit 2 payload checksum error, bit 3 overflow, as taken from `wrErr` (bits 0..2 in that same order). With `cfgFwdErr`=1 error frames are delivered with this status.
- R8: In threshold mode no frame is ever removed; error frames are delivered with their status.
- R9: A frame byte that arrives while DEPTH-1 words are held, and is not an end beat, is stored as the frame's last byte with status 8 (overflow), and the remaining bytes up to the end beat are discarded; in whole-frame mode with `cfgFwdErr`=0 the truncated frame is removed instead.
- R10: Changing `cfgStoreFwd`, `cfgFwdErr`, `cfgKeepCsum` or `cfgThreshold` during a frame has no effect on that frame.
- R11: Bytes with `wrValid` high outside a frame (no start seen) are ignored, and a frame whose start beat arrives while the buffer is full is discarded completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStoreFwd | input | 1 | 1: whole-frame mode, 0: threshold mode |
| cfgFwdErr | input | 1 | 1: deliver error frames instead of removing them |
| cfgKeepCsum | input | 1 | 1: keep frames whose only error is the payload checksum |
| cfgThreshold | input | THR_W | Stored byte count that opens a frame in threshold mode |
| wrValid | input | 1 | Write beat present |
| wrSof | input | 1 | Beat is the first byte of a frame |
| wrEof | input | 1 | Beat is the last byte of a frame |
| wrData | input | DATA_W | Frame byte |
| wrErr | input | 3 | End-beat error flags: bit 0 FCS, bit 1 MAC, bit 2 payload checksum |
| rdReady | input | 1 | Reader accepts the current byte |
| rdValid | output | 1 | A byte is available |
| rdData | output | DATA_W | Byte at the read head |
| rdLast | output | 1 | Current byte ends its frame |
| rdStatus | output | 4 | Frame status on the last byte, zero otherwise |

## Verification
Every write beat is registered once, so a frame's readability changes exactly one edge after the beat that completes it (whole-frame mode) or reaches the threshold (threshold mode), and a pop moves the read head at the edge where `rdValid` and `rdReady` are both high. The bench drives beats just after a rising edge and samples at the following falling edge, so the "not yet readable" check falls in the cycle before the deciding beat's edge and the "readable" check in the cycle after it. A scoreboard queue filled by the frame driver holds each expected byte, last flag and status, and a monitor compares them at every falling edge where a pop is due.

// File: rtl/rxFifoPkg.sv
package rxFifoPkg;

  localparam int STAT_W = 4;
  localparam int ST_FCS  = 0;
  localparam int ST_MAC  = 1;
  localparam int ST_CSUM = 2;
  localparam int ST_OVF  = 3;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_FILL,
    WR_SKIP
  } wrState_t;

  // Strobes from the write control to the storage datapath
  typedef struct packed {
    logic              push;
    logic              last;
    logic [STAT_W-1:0] stat;
    logic              saveStart;
    logic              rewind;
    logic              commit;
    logic              openCut;
  } fifoCmd_t;

endpackage

// File: rtl/rxFifoCtrl.sv
module rxFifoCtrl
  import rxFifoPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int THR_W = 8,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgStoreFwd,
  input  logic                cfgFwdErr,
  input  logic                cfgKeepCsum,
  input  logic [THR_W-1:0]    cfgThreshold,
  input  logic                wrValid,
  input  logic                wrSof,
  input  logic                wrEof,
  input  logic [STAT_W-2:0]   wrErr,
  input  logic [PW-1:0]       used,
  output fifoCmd_t            cmd
);

  wrState_t         state, nextState;
  logic             frmSf, frmFwd, frmKeep;
  logic [THR_W-1:0] frmThr, frmCnt, nextCnt;

  logic             startBeat, contBeat, skipEnd;
  logic             sfNow, fwdNow, keepNow;
  logic [THR_W-1:0] thrNow, cntNow, cntNext;
  logic             isFull, nearFull, badStat;

  assign startBeat = wrValid && wrSof;
  assign contBeat  = wrValid && !wrSof && (state == WR_FILL);
  assign skipEnd   = wrValid && !wrSof && wrEof && (state == WR_SKIP);

  // Mode is taken live on the start beat, from the latched copy afterwards
  assign sfNow   = startBeat ? cfgStoreFwd  : frmSf;
  assign fwdNow  = startBeat ? cfgFwdErr    : frmFwd;
  assign keepNow = startBeat ? cfgKeepCsum  : frmKeep;
  assign thrNow  = startBeat ? cfgThreshold : frmThr;
  assign cntNow  = startBeat ? '0 : frmCnt;
  assign cntNext = (cntNow == '1) ? cntNow : cntNow + 1'b1;

  assign isFull   = (used == PW'(DEPTH));
  assign nearFull = (used == PW'(DEPTH - 1));
  assign badStat  = wrErr[ST_FCS] || wrErr[ST_MAC] || (wrErr[ST_CSUM] && !keepNow);

  always_comb begin
    cmd       = '0;
    nextState = state;
    nextCnt   = frmCnt;
    if (startBeat || contBeat) begin
      cmd.saveStart = startBeat;
      if (startBeat && isFull) begin
        nextState = wrEof ? WR_IDLE : WR_SKIP;
      end else if (nearFull && !wrEof) begin
        nextState = WR_SKIP;
        if (sfNow && !fwdNow) begin
          cmd.rewind = !startBeat;
        end else begin
          cmd.push         = 1'b1;
          cmd.last         = 1'b1;
          cmd.stat[ST_OVF] = 1'b1;
          cmd.commit       = 1'b1;
        end
      end else if (wrEof) begin
        nextState = WR_IDLE;
        if (sfNow && !fwdNow && badStat) begin
          cmd.rewind = !startBeat;
        end else begin
          cmd.push   = 1'b1;
          cmd.last   = 1'b1;
          cmd.stat   = {1'b0, wrErr};
          cmd.commit = 1'b1;
        end
      end else begin
        nextState   = WR_FILL;
        cmd.push    = 1'b1;
        nextCnt     = cntNext;
        cmd.openCut = !sfNow && (cntNext >= thrNow);
      end
    end else if (skipEnd) begin
      nextState = WR_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= WR_IDLE;
      frmSf   <= 1'b0;
      frmFwd  <= 1'b0;
      frmKeep <= 1'b0;
      frmThr  <= '0;
      frmCnt  <= '0;
    end else begin
      state  <= nextState;
      frmCnt <= nextCnt;
      if (startBeat) begin
        frmSf   <= cfgStoreFwd;
        frmFwd  <= cfgFwdErr;
        frmKeep <= cfgKeepCsum;
        frmThr  <= cfgThreshold;
      end
    end
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == WR_FILL && !startBeat) |=> ($stable(frmSf) && $stable(frmFwd) && $stable(frmThr)));

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == WR_SKIP && !startBeat) |-> !cmd.push);

endmodule

// File: rtl/rxFifoData.sv
module rxFifoData
  import rxFifoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int WORD_W = DATA_W + 1 + STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic [STAT_W-1:0] rdStatus,
  output logic [PW-1:0]     used
);

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr, startPtr, commitPtr, availPtr;
  logic              ctOpen;
  logic [WORD_W-1:0] headWord;

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.rewind) begin
      mem[wrPtr[AW-1:0]] <= {cmd.last, cmd.stat, wrData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      startPtr  <= '0;
      commitPtr <= '0;
      ctOpen    <= 1'b0;
    end else begin
      if (cmd.rewind) begin
        wrPtr <= startPtr;
      end else if (cmd.push) begin
        wrPtr <= wrPtr + ONE;
      end
      if (cmd.saveStart) begin
        startPtr <= wrPtr;
      end
      if (cmd.commit) begin
        commitPtr <= wrPtr + ONE;
        ctOpen    <= 1'b0;
      end else if (cmd.openCut) begin
        ctOpen <= 1'b1;
      end
      if (rdValid && rdReady) begin
        rdPtr <= rdPtr + ONE;
      end
    end
  end

  assign availPtr = ctOpen ? wrPtr : commitPtr;
  assign rdValid  = (rdPtr != availPtr);
  assign headWord = mem[rdPtr[AW-1:0]];
  assign rdData   = headWord[DATA_W-1:0];
  assign rdLast   = rdValid && headWord[WORD_W-1];
  assign rdStatus = rdLast ? headWord[DATA_W +: STAT_W] : '0;
  assign used     = wrPtr - rdPtr;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> (used != PW'(DEPTH)));

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData) && $stable(rdLast)));

  // R8
  no_cut_rewind_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rewind |-> !ctOpen);

  // R2
  commit_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> (cmd.push && cmd.last));

endmodule

// File: rtl/rxFrameFifo.sv
module rxFrameFifo
  import rxFifoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int THR_W  = 8,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStoreFwd,
  input  logic              cfgFwdErr,
  input  logic              cfgKeepCsum,
  input  logic [THR_W-1:0]  cfgThreshold,
  input  logic              wrValid,
  input  logic              wrSof,
  input  logic              wrEof,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        wrErr,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic [3:0]        rdStatus
);

  fifoCmd_t      cmd;
  logic [PW-1:0] used;

  rxFifoCtrl #(.DEPTH(DEPTH), .THR_W(THR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgStoreFwd(cfgStoreFwd), .cfgFwdErr(cfgFwdErr),
    .cfgKeepCsum(cfgKeepCsum), .cfgThreshold(cfgThreshold),
    .wrValid(wrValid), .wrSof(wrSof), .wrEof(wrEof), .wrErr(wrErr),
    .used(used), .cmd(cmd)
  );

  rxFifoData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .rdLast(rdLast), .rdStatus(rdStatus), .used(used)
  );

endmodule

// File: tb/test_rxFrameFifo.sv
module test_rxFrameFifo;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgStoreFwd = 1'b1, cfgFwdErr = 1'b0, cfgKeepCsum = 1'b0;
  logic [7:0] cfgThreshold = 8'd1;
  logic       wrValid = 1'b0, wrSof = 1'b0, wrEof = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] wrErr = '0;
  logic       rdReady = 1'b0;
  logic       rdValid, rdLast;
  logic [7:0] rdData;
  logic [3:0] rdStatus;

  int nChecks = 0;
  int nFail = 0;
  int readMode = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] d;
    logic       l;
    logic [3:0] s;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  rxFrameFifo #(.DATA_W(8), .DEPTH(DEPTH), .THR_W(8)) i_rxFrameFifo (
    .clk(clk), .rstN(rstN),
    .cfgStoreFwd(cfgStoreFwd), .cfgFwdErr(cfgFwdErr), .cfgKeepCsum(cfgKeepCsum),
    .cfgThreshold(cfgThreshold),
    .wrValid(wrValid), .wrSof(wrSof), .wrEof(wrEof), .wrData(wrData), .wrErr(wrErr),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast),
    .rdStatus(rdStatus)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Reader ready pattern
  initial begin
    forever begin
      @(posedge clk); #1;
      case (readMode)
        0: rdReady = 1'b0;
        1: rdReady = 1'b1;
        default: rdReady = 1'($urandom % 2);
      endcase
    end
  end

  // Monitor: compare every pop against the scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid && rdReady) begin
      if (expQ.size() == 0) begin
        chk(0, "R4 unexpected byte", int'(rdData), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk({rdData, rdLast, rdStatus} == {e.d, e.l, e.s}, e.req,
            int'({rdData, rdLast, rdStatus}), int'({e.d, e.l, e.s}));
      end
    end
  end

  // Expected bytes of a frame: keepN bytes delivered, last one carries stat
  function automatic void pushExp(input int keepN, input int seed, input logic [3:0] stat,
                                  input string req);
    for (int i = 0; i < keepN; i++) begin
      expItem_t e;
      e.d = 8'(seed + i);
      e.l = (i == keepN - 1);
      e.s = (i == keepN - 1) ? stat : 4'd0;
      e.req = req;
      expQ.push_back(e);
    end
  endfunction

  // Drive beats [from, to) of an n-byte frame; returns just after the write edge
  task automatic driveRange(input int n, input int seed, input logic [2:0] err,
                            input int from, input int to);
    for (int i = from; i < to; i++) begin
      wrValid = 1'b1;
      wrSof   = (i == 0);
      wrEof   = (i == n - 1);
      wrData  = 8'(seed + i);
      wrErr   = (i == n - 1) ? err : 3'd0;
      @(posedge clk); #1;
    end
    wrValid = 1'b0; wrSof = 1'b0; wrEof = 1'b0; wrErr = '0;
  endtask

  task automatic frame(input int n, input int seed, input logic [2:0] err);
    driveRange(n, seed, err, 0, n);
  endtask

  task automatic setCfg(input logic sf, input logic fwd, input logic keep, input int thr);
    cfgStoreFwd = sf; cfgFwdErr = fwd; cfgKeepCsum = keep; cfgThreshold = 8'(thr);
  endtask

  task automatic waitDrain(input string req);
    int guard = 0;
    while (expQ.size() != 0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(expQ.size() == 0, req, expQ.size(), 0);
    chk(rdValid == 1'b0, req, int'(rdValid), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finishUp();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: nothing readable after reset
    chk(rdValid == 1'b0, "R1", int'(rdValid), 0);
    @(posedge clk); #1;

    // R2: whole-frame mode holds data until the end beat
    setCfg(1, 0, 0, 1);
    readMode = 0;
    pushExp(5, 8'h10, 4'd0, "R2");
    driveRange(5, 8'h10, 3'd0, 0, 4);
    @(negedge clk);
    chk(rdValid == 1'b0, "R2 before end", int'(rdValid), 0);
    @(posedge clk); #1;
    driveRange(5, 8'h10, 3'd0, 4, 5);
    @(negedge clk);
    chk(rdValid == 1'b1, "R2 after end", int'(rdValid), 1);
    @(posedge clk); #1;
    readMode = 1;
    waitDrain("R2 drain");

    // R3: threshold mode opens at the threshold count
    readMode = 0;
    setCfg(0, 0, 0, 4);
    pushExp(8, 8'h20, 4'd0, "R3");
    driveRange(8, 8'h20, 3'd0, 0, 3);
    @(negedge clk);
    chk(rdValid == 1'b0, "R3 below threshold", int'(rdValid), 0);
    @(posedge clk); #1;
    driveRange(8, 8'h20, 3'd0, 3, 4);
    @(negedge clk);
    chk(rdValid == 1'b1, "R3 at threshold", int'(rdValid), 1);
    @(posedge clk); #1;
    driveRange(8, 8'h20, 3'd0, 4, 8);
    readMode = 2;
    waitDrain("R3 drain");

    // R5: FCS and MAC error frames removed, neighbours intact; R4 order with stalls
    setCfg(1, 0, 0, 1);
    readMode = 2;
    pushExp(3, 8'h30, 4'd0, "R5 good1"); frame(3, 8'h30, 3'd0);
    frame(4, 8'h40, 3'b001);
    pushExp(1, 8'h50, 4'd0, "R4 single"); frame(1, 8'h50, 3'd0);
    frame(5, 8'h60, 3'b010);
    pushExp(6, 8'h70, 4'd0, "R4 good2"); frame(6, 8'h70, 3'd0);
    frame(1, 8'h78, 3'b001);
    waitDrain("R5 drain");

    // R6: payload-checksum-only handling
    setCfg(1, 0, 1, 1);
    pushExp(4, 8'h80, 4'd4, "R6 kept"); frame(4, 8'h80, 3'b100);
    frame(3, 8'h88, 3'b101);
    setCfg(1, 0, 0, 1);
    frame(3, 8'h90, 3'b100);
    pushExp(2, 8'h98, 4'd0, "R6 after"); frame(2, 8'h98, 3'd0);
    waitDrain("R6 drain");

    // R7: forwarding delivers error status on the last byte only
    setCfg(1, 1, 0, 1);
    pushExp(3, 8'hA0, 4'd1, "R7 fcs"); frame(3, 8'hA0, 3'b001);
    pushExp(4, 8'hA8, 4'd2, "R7 mac"); frame(4, 8'hA8, 3'b010);
    pushExp(2, 8'hB0, 4'd7, "R7 all"); frame(2, 8'hB0, 3'b111);
    waitDrain("R7 drain");

    // R8: threshold mode never removes
    setCfg(0, 0, 0, 2);
    pushExp(5, 8'hB8, 4'd1, "R8 fcs"); frame(5, 8'hB8, 3'b001);
    pushExp(3, 8'hC0, 4'd4, "R8 csum"); frame(3, 8'hC0, 3'b100);
    waitDrain("R8 drain");

    // R10: config changes mid-frame are ignored
    readMode = 0;
    setCfg(1, 0, 0, 1);
    pushExp(6, 8'hC8, 4'd0, "R10 sf");
    driveRange(6, 8'hC8, 3'd0, 0, 2);
    setCfg(0, 1, 1, 1);
    driveRange(6, 8'hC8, 3'd0, 2, 4);
    @(negedge clk);
    chk(rdValid == 1'b0, "R10 still whole-frame", int'(rdValid), 0);
    @(posedge clk); #1;
    driveRange(6, 8'hC8, 3'd0, 4, 6);
    readMode = 1;
    waitDrain("R10 drain1");
    setCfg(0, 0, 0, 1);
    pushExp(4, 8'hD0, 4'd1, "R10 ct");
    driveRange(4, 8'hD0, 3'b001, 0, 1);
    setCfg(1, 0, 0, 1);
    driveRange(4, 8'hD0, 3'b001, 1, 4);
    waitDrain("R10 drain2");

    // R11: bytes outside a frame are ignored
    readMode = 0;
    for (int i = 0; i < 3; i++) begin
      wrValid = 1'b1; wrData = 8'(8'hE0 + i); wrEof = (i == 2);
      @(posedge clk); #1;
    end
    wrValid = 1'b0; wrEof = 1'b0;
    @(negedge clk);
    chk(rdValid == 1'b0, "R11 stray bytes", int'(rdValid), 0);
    @(posedge clk); #1;

    // R9: truncation with forwarding, then R11 frame while full
    setCfg(1, 1, 0, 1);
    pushExp(DEPTH, 8'h00, 4'd8, "R9 truncated");
    frame(20, 8'h00, 3'd0);
    frame(3, 8'hF0, 3'd0);
    @(negedge clk);
    chk(rdValid == 1'b1, "R9 truncated readable", int'(rdValid), 1);
    @(posedge clk); #1;
    readMode = 1;
    waitDrain("R11 full drop");

    // R9: truncation with removal in whole-frame mode
    readMode = 0;
    setCfg(1, 0, 0, 1);
    frame(20, 8'h40, 3'd0);
    @(negedge clk);
    chk(rdValid == 1'b0, "R9 removed", int'(rdValid), 0);
    @(posedge clk); #1;
    pushExp(3, 8'hF8, 4'd0, "R9 after removal"); frame(3, 8'hF8, 3'd0);
    readMode = 1;
    waitDrain("R9 drain");

    done = 1;
    finishUp();
  end

endmodule